// File: doc/BRIEF.md
# Strobed Serial-to-Parallel Output Driver

This block takes serial data from a microcontroller and presents it on a wide bank of parallel output lines, for example to drive a row of LEDs. Each rising edge of an external shift clock moves the data one stage along a shift register. A level-sensitive output latch sits behind the register. While the active-low strobe is asserted the latch is transparent, and while it is released the latch holds. An active-low clear drives every latch bit high. The last register stage is also brought out as a cascade output, so several instances can be chained by feeding one instance's cascade output into the next instance's data input.

All of the block runs on one system clock. The external shift clock, strobe, clear and data pins pass through a two-flop synchronizer first. The control logic then finds rising edges of the shift clock and decodes the strobe and clear levels into a small set of strobes for the datapath. The width is a parameter and defaults to 24 lines.

Top module: `sdrv_top`

## Requirements
- R1: After reset the shift register holds all zeros, so the cascade output is 0, and every parallel output is 1.
- R2: On each detected rising edge of the external shift clock, stage 0 takes the serial data bit and every stage i>0 takes the old value of stage i-1.
- R3: After WIDTH rising edges, the bit shifted in first sits in stage WIDTH-1. A word sent most significant bit first therefore appears in the register with bit i at stage i, and parallel output i shows stage i.
- R4: While the strobe input is low and the clear input is high, the latch follows the shift register, so a shift in that time changes the parallel outputs on the same system clock edge as the register.
- R5: While the strobe input is high, the parallel outputs keep their value whatever the shift clock and data inputs do.
- R6: While the clear input is low, every parallel output is 1. The shift register keeps its contents and keeps shifting, so that releasing the clear with the strobe low shows the register's current value.
- R7: Clear takes priority over strobe: when both are low, the outputs stay all ones, even across shifts.
- R8: The cascade output always equals stage WIDTH-1 and changes only on a shift, whatever the strobe and clear are doing.
- R9: A change on any external input is sampled at a system clock edge and reaches the outputs two system clock edges after that sampling edge.
- R10: A shift clock held high, or a falling edge of it, causes no shift. Only one shift happens per low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial data input, asynchronous |
| shiftClkIn | input | 1 | External shift clock, asynchronous; rising edge shifts |
| strobeN | input | 1 | Active-low latch strobe, level sensitive |
| clearN | input | 1 | Active-low latch clear, level sensitive |
| parOut | output | WIDTH | Parallel outputs, bit i from latch stage i |
| cascadeOut | output | 1 | Last shift register stage, for chaining |

## Verification
The assertions check on every cycle that a detected edge moves the register by exactly one stage and that no shift happens without one. They also check that the latch is all ones after a clear, that it holds when neither strobe nor clear is active, and that it matches the register after a transparent load. Other properties require detected edges never to fall on two consecutive cycles and the cascade output to stay steady between shifts. The bench scenarios are needed for the behaviour seen only at the pins. These are the two-cycle synchronizer latency, the bit order of a whole frame, the survival of the register contents across a clear, and the priority of clear over a transparent strobe. A behavioural model compares both outputs on every cycle.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;

  // Strobes from the control module to the datapath, one system cycle each
  typedef struct packed {
    logic shiftEn;    // move the register one stage this cycle
    logic latchLoad;  // latch is transparent this cycle
    logic latchClear; // latch forced to all ones this cycle
  } drvCtrl_t;

  // Bit positions in the synchronized input bundle
  localparam int IDX_CLEAR  = 0;
  localparam int IDX_STROBE = 1;
  localparam int IDX_SCLK   = 2;
  localparam int IDX_DATA   = 3;
  localparam int IN_COUNT   = 4;

endpackage

// File: rtl/sdrv_sync.sv
module sdrv_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sdrv_ctrl.sv
module sdrv_ctrl
  import sdrv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     shiftClkSync,
  input  logic     strobeNSync,
  input  logic     clearNSync,
  output drvCtrl_t ctrlOut
);

  logic prevClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevClk <= 1'b0;
    else       prevClk <= shiftClkSync;
  end

  always_comb begin
    ctrlOut.shiftEn    = shiftClkSync & ~prevClk;
    ctrlOut.latchClear = ~clearNSync;
    // clear wins over strobe
    ctrlOut.latchLoad  = ~strobeNSync & clearNSync;
  end

  // R10: a detected edge lasts one cycle; the clock must fall and rise again
  p_single_shift_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.shiftEn |=> !ctrlOut.shiftEn);

  // R7: never load and clear in the same cycle
  p_clear_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.latchClear |-> !ctrlOut.latchLoad);

endmodule

// File: rtl/sdrv_datapath.sv
module sdrv_datapath
  import sdrv_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  drvCtrl_t         ctrlIn,
  input  logic             dataBit,
  output logic [WIDTH-1:0] parOut,
  output logic             cascadeOut
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] shregNext;
  logic [WIDTH-1:0] latch;

  always_comb begin
    if (ctrlIn.shiftEn) shregNext = {shreg[WIDTH-2:0], dataBit};
    else                shregNext = shreg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shreg <= '0;
    else       shreg <= shregNext;
  end

  // Transparent latch modelled as a register fed by the next register value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  latch <= ALL_ONES;
    else if (ctrlIn.latchClear) latch <= ALL_ONES;
    else if (ctrlIn.latchLoad)  latch <= shregNext;
  end

  assign parOut     = latch;
  assign cascadeOut = shreg[WIDTH-1];

  // R2: one-stage move with new bit at stage 0
  p_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.shiftEn |=> shreg == {$past(shreg[WIDTH-2:0]), $past(dataBit)});

  // R10: no edge, no movement
  p_no_shift_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.shiftEn |=> $stable(shreg));

  // R6: clear gives all ones
  p_clear_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.latchClear |=> (latch == ALL_ONES));

  // R5: hold while strobe released and no clear
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.latchLoad && !ctrlIn.latchClear) |=> $stable(latch));

  // R4: transparent load tracks the register in the same cycle
  p_transparent_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.latchLoad |=> (latch == shreg));

  // R8: cascade moves only on a shift
  p_cascade_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.shiftEn |=> $stable(cascadeOut));

endmodule

// File: rtl/sdrv_top.sv
module sdrv_top
  import sdrv_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             shiftClkIn,
  input  logic             strobeN,
  input  logic             clearN,
  output logic [WIDTH-1:0] parOut,
  output logic             cascadeOut
);

  // Idle levels: data 0, clock 0, strobe released, clear released
  localparam logic [IN_COUNT-1:0] SYNC_RESET = 4'b0011;

  logic [IN_COUNT-1:0] rawIn;
  logic [IN_COUNT-1:0] syncIn;
  drvCtrl_t            ctrl;

  always_comb begin
    rawIn             = '0;
    rawIn[IDX_CLEAR]  = clearN;
    rawIn[IDX_STROBE] = strobeN;
    rawIn[IDX_SCLK]   = shiftClkIn;
    rawIn[IDX_DATA]   = serIn;
  end

  sdrv_sync #(
    .WIDTH    (IN_COUNT),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(SYNC_RESET)
  ) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawIn),
    .syncOut(syncIn)
  );

  sdrv_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .shiftClkSync(syncIn[IDX_SCLK]),
    .strobeNSync (syncIn[IDX_STROBE]),
    .clearNSync  (syncIn[IDX_CLEAR]),
    .ctrlOut     (ctrl)
  );

  sdrv_datapath #(
    .WIDTH(WIDTH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIn    (ctrl),
    .dataBit   (syncIn[IDX_DATA]),
    .parOut    (parOut),
    .cascadeOut(cascadeOut)
  );

endmodule

// File: tb/sdrv_top_tb.sv
module sdrv_top_tb_top;

  localparam int W = 24;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic shiftClkIn = 1'b0;
  logic strobeN = 1'b1;
  logic clearN = 1'b1;
  logic [W-1:0] parOut;
  logic cascadeOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdrv_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .shiftClkIn(shiftClkIn),
    .strobeN(strobeN), .clearN(clearN), .parOut(parOut), .cascadeOut(cascadeOut)
  );

  // Behavioural reference: input history line plus register and latch words
  logic [W-1:0] mSh;
  logic [W-1:0] mLat;
  logic hData [3];
  logic hClk [3];
  logic hStb [3];
  logic hClr [3];

  always @(posedge clk) begin
    if (!rstN) begin
      mSh = '0;
      mLat = '1;
      for (int i = 0; i < 3; i++) begin
        hData[i] = 1'b0; hClk[i] = 1'b0; hStb[i] = 1'b1; hClr[i] = 1'b1;
      end
    end else begin
      if (hClk[1] && !hClk[2]) mSh = {mSh[W-2:0], hData[1]};
      if (!hClr[1]) mLat = '1;
      else if (!hStb[1]) mLat = mSh;
      for (int i = 2; i > 0; i--) begin
        hData[i] = hData[i-1]; hClk[i] = hClk[i-1];
        hStb[i] = hStb[i-1]; hClr[i] = hClr[i-1];
      end
      hData[0] = serIn; hClk[0] = shiftClkIn; hStb[0] = strobeN; hClr[0] = clearN;
    end
  end

  // Every-cycle comparison against the model (R2 R4 R5 R6 R8 R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (parOut !== mLat || cascadeOut !== mSh[W-1]) begin
        failures++;
        $display("FAIL R2 R4 R5 R6 R8 R9 model: parOut=%h casc=%b expected parOut=%h casc=%b",
                 parOut, cascadeOut, mLat, mSh[W-1]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chkWord(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    serIn = b;
    shiftClkIn = 1'b1;
    waitN(3);
    shiftClkIn = 1'b0;
    waitN(3);
  endtask

  task automatic sendWord(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  localparam logic [W-1:0] WORD_A = 24'h5A3C96;
  localparam logic [W-1:0] WORD_B = 24'hC0FFE1;

  initial begin
    logic [W-1:0] expSh;
    waitN(4);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state
    chkWord("R1 reset parOut", parOut, '1);
    chkBit("R1 reset cascade", cascadeOut, 1'b0);

    // R5 frame with strobe high leaves outputs untouched; R3 R8 cascade
    sendWord(WORD_A);
    chkWord("R5 hold during frame", parOut, '1);
    chkBit("R3 R8 cascade first bit", cascadeOut, WORD_A[W-1]);

    // R9 latency of strobe, then R3 R4 transparent result
    strobeN = 1'b0;
    waitN(1);
    chkWord("R9 no change after 1 edge", parOut, '1);
    waitN(1);
    chkWord("R9 no change after 2 edges", parOut, '1);
    waitN(1);
    chkWord("R9 R3 R4 frame visible", parOut, WORD_A);

    // R4 R2 shift while transparent
    shiftBit(1'b1);
    expSh = {WORD_A[W-2:0], 1'b1};
    chkWord("R4 R2 transparent shift", parOut, expSh);

    // R10 clock held high shifts once only
    serIn = 1'b0;
    shiftClkIn = 1'b1;
    waitN(12);
    expSh = {expSh[W-2:0], 1'b0};
    chkWord("R10 held high single shift", parOut, expSh);
    serIn = 1'b1;
    shiftClkIn = 1'b0;
    waitN(8);
    chkWord("R10 falling edge no shift", parOut, expSh);

    // R6 clear with strobe high
    strobeN = 1'b1;
    waitN(4);
    clearN = 1'b0;
    waitN(4);
    chkWord("R6 clear forces ones", parOut, '1);
    // R7 clear beats strobe, even across a shift
    strobeN = 1'b0;
    waitN(4);
    chkWord("R7 clear priority", parOut, '1);
    shiftBit(1'b0);
    expSh = {expSh[W-2:0], 1'b0};
    chkWord("R7 clear priority across shift", parOut, '1);
    chkBit("R8 cascade shifts under clear", cascadeOut, expSh[W-1]);
    // R6 register survived the clear
    clearN = 1'b1;
    waitN(4);
    chkWord("R6 register kept through clear", parOut, expSh);

    // R8 R3 second frame with strobe high, cascade order
    strobeN = 1'b1;
    waitN(4);
    sendWord(WORD_B);
    chkWord("R5 hold second frame", parOut, expSh);
    chkBit("R3 R8 cascade after frame", cascadeOut, WORD_B[W-1]);
    shiftBit(1'b1);
    chkBit("R8 cascade next bit", cascadeOut, WORD_B[W-2]);
    strobeN = 1'b0;
    waitN(4);
    chkWord("R3 R4 second frame visible", parOut, {WORD_B[W-2:0], 1'b1});
    waitN(4);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule